// File: doc/BRIEF.md
# Serial Controller Control-Word Sequencer

This block sits behind the single control address of a serial controller. Software writes every configuration byte to that one address: the operating-mode byte, any sync characters, and all later commands. The block counts the bytes written since the last reset and places each one in the right register. After the mode byte it decodes the operating mode, clock divisor, character length, parity and stop-bit setting, and it drives those fields to the serial datapath as registered outputs.

The first write after a reset is always the mode byte. A synchronous mode byte is followed by one or two sync characters, and the mode byte sets how many. Every write after that is a command. A command with its internal-reset bit set sends the sequencer back to waiting for a mode byte. The external reset does the same. A 2-bit phase output shows which register the next write will land in.

Top module: `ctlseq_top`

## Requirements
- R1: While `rst` is high, on the next clock edge `phase` becomes 0 (expecting the mode byte) and all four byte registers clear to 0. The decoded fields then show what mode byte 0x00 gives: `sync_mode`=1, `sync_count`=2, `baud_div`=1, `data_bits`=5, `parity_en`=0, `parity_even`=0, `stop_halves`=0.
- R2: A write in phase 0 is stored in `mode_byte`. If bits 1:0 of that byte are non-zero (asynchronous), `phase` becomes 3 (command).
- R3: If bits 1:0 of the mode byte are 00 (synchronous), `phase` becomes 1. The next write goes to `sync1_byte`. If mode bit 7 is 1, one sync character is expected and `phase` then becomes 3. If bit 7 is 0, the write after that goes to `sync2_byte` and `phase` becomes 3.
- R4: In phase 3, each write is stored in `cmd_byte` and `phase` stays 3, unless R5 applies.
- R5: A command write with bit 6 set is stored in `cmd_byte` and sets `phase` to 0, so the next write is taken as a mode byte.
- R6: If `rst` and `ctl_wr` are high in the same cycle, the reset wins. `phase` becomes 0 and no register takes the written byte.
- R7: `baud_div` follows mode bits 1:0: 01 gives 1, 10 gives 16, 11 gives 64. In synchronous mode (00) it is 1.
- R8: `data_bits` equals 5 plus mode bits 3:2, so the range is 5 to 8.
- R9: `parity_en` follows mode bit 4. `parity_even` follows mode bit 5 when parity is enabled and is 0 otherwise.
- R10: `stop_halves` gives the stop length in half-bit units. In asynchronous mode, bits 7:6 of 01 give 2, 10 give 3 and 11 give 4; 00 gives 0. In synchronous mode it is 0. `sync_count` is 0 in asynchronous mode.
- R11: While `ctl_wr` is low, `phase`, all byte registers and all decoded fields hold their values.
- R12: A write changes only the register picked by the current phase. The other three registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| ctl_wr | input | 1 | Control-write strobe, one byte per high cycle |
| ctl_data | input | 8 | Control byte |
| phase | output | 2 | Destination of the next write: 0 mode, 1 first sync, 2 second sync, 3 command |
| mode_byte | output | 8 | Stored mode byte |
| sync1_byte | output | 8 | First sync character |
| sync2_byte | output | 8 | Second sync character |
| cmd_byte | output | 8 | Last command byte |
| sync_mode | output | 1 | 1 when synchronous mode is selected |
| sync_count | output | 2 | Number of sync characters (0 in asynchronous mode) |
| baud_div | output | 7 | Clock cycles per bit: 1, 16 or 64 |
| data_bits | output | 4 | Data bits per character, 5 to 8 |
| parity_en | output | 1 | Parity bit present |
| parity_even | output | 1 | Even parity when enabled |
| stop_halves | output | 3 | Stop length in half-bit units |

## Verification
Two events can land in the same cycle: an external reset and a control write. The bench raises `rst` and `ctl_wr` on the same falling edge, with the sequencer part-way through a configuration. It then checks that `phase` is 0 and that `mode_byte` is 0 rather than the byte that was written. The command write that carries the internal-reset bit also does two things in one cycle: it stores the command and sends the sequencer back to the mode phase. The bench checks both results after that single edge, then checks that the following write is decoded as a mode byte.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;

  localparam int BYTE_W = 8;
  localparam int NUM_REGS = 4;
  localparam int BAUD_W = 7;

  // Field positions used by the sequencer and decoder
  localparam int SYNC_ONE_BIT = 7;
  localparam int IRST_BIT = 6;
  localparam int PAR_EN_BIT = 4;
  localparam int PAR_EVEN_BIT = 5;

  typedef enum logic [1:0] {
    PH_MODE  = 2'd0,
    PH_SYNC1 = 2'd1,
    PH_SYNC2 = 2'd2,
    PH_CMD   = 2'd3
  } phase_e;

  // Register slots, in load-vector order
  localparam int SLOT_MODE = 0;
  localparam int SLOT_SYNC1 = 1;
  localparam int SLOT_SYNC2 = 2;
  localparam int SLOT_CMD = 3;

  typedef struct packed {
    logic              sync_mode;
    logic [1:0]        sync_count;
    logic [BAUD_W-1:0] baud_div;
    logic [3:0]        data_bits;
    logic              parity_en;
    logic              parity_even;
    logic [2:0]        stop_halves;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [BYTE_W-1:0] m);
    mode_cfg_t c;
    c.sync_mode = (m[1:0] == 2'b00);
    case (m[1:0])
      2'b10:   c.baud_div = BAUD_W'(16);
      2'b11:   c.baud_div = BAUD_W'(64);
      default: c.baud_div = BAUD_W'(1);
    endcase
    c.data_bits = 4'd5 + {2'b00, m[3:2]};
    c.parity_en = m[PAR_EN_BIT];
    c.parity_even = m[PAR_EN_BIT] & m[PAR_EVEN_BIT];
    if (c.sync_mode) begin
      c.stop_halves = 3'd0;
      c.sync_count = m[SYNC_ONE_BIT] ? 2'd1 : 2'd2;
    end else begin
      c.sync_count = 2'd0;
      case (m[7:6])
        2'b01:   c.stop_halves = 3'd2;
        2'b10:   c.stop_halves = 3'd3;
        2'b11:   c.stop_halves = 3'd4;
        default: c.stop_halves = 3'd0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ctlseq_fsm.sv
module ctlseq_fsm
  import ctlseq_pkg::*;
#(
  parameter int NREG = NUM_REGS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            async_sel,
  input  logic            irst_req,
  input  logic            one_sync,
  output phase_e          phase,
  output logic [NREG-1:0] ld
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    ld = '0;
    if (wr) begin
      unique case (phase_q)
        PH_MODE: begin
          ld[SLOT_MODE] = 1'b1;
          phase_d = async_sel ? PH_CMD : PH_SYNC1;
        end
        PH_SYNC1: begin
          ld[SLOT_SYNC1] = 1'b1;
          phase_d = one_sync ? PH_CMD : PH_SYNC2;
        end
        PH_SYNC2: begin
          ld[SLOT_SYNC2] = 1'b1;
          phase_d = PH_CMD;
        end
        PH_CMD: begin
          ld[SLOT_CMD] = 1'b1;
          phase_d = irst_req ? PH_MODE : PH_CMD;
        end
        default: phase_d = PH_MODE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_MODE;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;

  // Reset wins over a simultaneous write (R1, R6)
  assert_reset_phase_R6: assert property (@(posedge clk)
    rst |=> phase_q == PH_MODE);

  assert_async_skip_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MODE && wr && async_sel) |=> phase_q == PH_CMD);

  assert_sync_enter_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MODE && wr && !async_sel) |=> phase_q == PH_SYNC1);

  assert_cmd_stay_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CMD && wr && !irst_req) |=> phase_q == PH_CMD);

  assert_irst_return_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CMD && wr && irst_req) |=> phase_q == PH_MODE);

  assert_idle_phase_R11: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(phase_q));

endmodule

// File: rtl/ctlseq_regs.sv
module ctlseq_regs #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        ld,
  input  logic [W-1:0]        d,
  output logic [N-1:0][W-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (ld[i]) q[i] <= d;
    end

    // A slot moves only when its own load fires (R11, R12)
    assert_slot_hold_R12: assert property (@(posedge clk) disable iff (rst)
      !ld[i] |=> $stable(q[i]));

    assert_slot_load_R12: assert property (@(posedge clk) disable iff (rst)
      ld[i] |=> q[i] == $past(d));
  end

endmodule

// File: rtl/ctlseq_decode.sv
module ctlseq_decode
  import ctlseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [BYTE_W-1:0] d,
  output mode_cfg_t         cfg
);

  mode_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= decode_mode('0);
    else if (ld) cfg_q <= decode_mode(d);
  end

  assign cfg = cfg_q;

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(cfg_q));

  assert_bits_range_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_q.data_bits >= 4'd5 && cfg_q.data_bits <= 4'd8);

endmodule

// File: rtl/ctlseq_top.sv
module ctlseq_top
  import ctlseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_data,
  output logic [1:0]  phase,
  output logic [7:0]  mode_byte,
  output logic [7:0]  sync1_byte,
  output logic [7:0]  sync2_byte,
  output logic [7:0]  cmd_byte,
  output logic        sync_mode,
  output logic [1:0]  sync_count,
  output logic [6:0]  baud_div,
  output logic [3:0]  data_bits,
  output logic        parity_en,
  output logic        parity_even,
  output logic [2:0]  stop_halves
);

  phase_e                          ph;
  logic [NUM_REGS-1:0]             ld;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
  mode_cfg_t                       cfg;

  ctlseq_fsm #(.NREG(NUM_REGS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctl_wr),
    .async_sel (|ctl_data[1:0]),
    .irst_req  (ctl_data[IRST_BIT]),
    .one_sync  (regs[SLOT_MODE][SYNC_ONE_BIT]),
    .phase     (ph),
    .ld        (ld)
  );

  ctlseq_regs #(.W(BYTE_W), .N(NUM_REGS)) u_regs (
    .clk (clk),
    .rst (rst),
    .ld  (ld),
    .d   (ctl_data),
    .q   (regs)
  );

  ctlseq_decode u_dec (
    .clk (clk),
    .rst (rst),
    .ld  (ld[SLOT_MODE]),
    .d   (ctl_data),
    .cfg (cfg)
  );

  assign phase       = ph;
  assign mode_byte   = regs[SLOT_MODE];
  assign sync1_byte  = regs[SLOT_SYNC1];
  assign sync2_byte  = regs[SLOT_SYNC2];
  assign cmd_byte    = regs[SLOT_CMD];
  assign sync_mode   = cfg.sync_mode;
  assign sync_count  = cfg.sync_count;
  assign baud_div    = cfg.baud_div;
  assign data_bits   = cfg.data_bits;
  assign parity_en   = cfg.parity_en;
  assign parity_even = cfg.parity_even;
  assign stop_halves = cfg.stop_halves;

  // Decoder and register file stay in step (R7, R10)
  assert_sync_match_R7: assert property (@(posedge clk) disable iff (rst)
    sync_mode == (mode_byte[1:0] == 2'b00));

  assert_sync_stop_R10: assert property (@(posedge clk) disable iff (rst)
    sync_mode |-> (stop_halves == 3'd0 && baud_div == 7'd1));

  // A sync-phase write never lands in the mode register (R12)
  assert_mode_guard_R12: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ph != PH_MODE) |=> $stable(mode_byte));

endmodule

// File: tb/tb_ctlseq_top.sv
`timescale 1ns/1ps
module tb_ctlseq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic [1:0] phase;
  logic [7:0] mode_byte, sync1_byte, sync2_byte, cmd_byte;
  logic       sync_mode, parity_en, parity_even;
  logic [1:0] sync_count;
  logic [6:0] baud_div;
  logic [3:0] data_bits;
  logic [2:0] stop_halves;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctlseq_top dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .phase(phase), .mode_byte(mode_byte), .sync1_byte(sync1_byte),
    .sync2_byte(sync2_byte), .cmd_byte(cmd_byte), .sync_mode(sync_mode),
    .sync_count(sync_count), .baud_div(baud_div), .data_bits(data_bits),
    .parity_en(parity_en), .parity_even(parity_even), .stop_halves(stop_halves)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_data = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk_cfg(input string req, input int sm, input int sc, input int bd,
                         input int db, input int pe, input int pv, input int sh);
    chk({req, " sync_mode"}, sync_mode, sm);
    chk({req, " sync_count"}, sync_count, sc);
    chk({req, " baud_div"}, baud_div, bd);
    chk({req, " data_bits"}, data_bits, db);
    chk({req, " parity_en"}, parity_en, pe);
    chk({req, " parity_even"}, parity_even, pv);
    chk({req, " stop_halves"}, stop_halves, sh);
  endtask

  // {byte written, expected phase afterwards}
  localparam logic [9:0] VEC [12] = '{
    {8'h4E, 2'd3},  // async mode -> command (R2)
    {8'h37, 2'd3},  // plain command (R4)
    {8'h40, 2'd0},  // internal reset command (R5)
    {8'h0C, 2'd1},  // sync, two characters (R3)
    {8'h16, 2'd2},
    {8'h16, 2'd3},
    {8'h15, 2'd3},  // R4
    {8'h40, 2'd0},  // R5
    {8'h80, 2'd1},  // sync, one character (R3)
    {8'hAA, 2'd3},
    {8'h40, 2'd0},
    {8'hFF, 2'd3}   // async x64
  };

  function automatic logic [7:0] reg_at(input int ph);
    case (ph)
      0: return mode_byte;
      1: return sync1_byte;
      2: return sync2_byte;
      default: return cmd_byte;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap_cmd, snap_mode;
    int prev_ph;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 phase", phase, 0);
    chk("R1 mode_byte", mode_byte, 0);
    chk("R1 sync1_byte", sync1_byte, 0);
    chk("R1 sync2_byte", sync2_byte, 0);
    chk("R1 cmd_byte", cmd_byte, 0);
    chk_cfg("R1", 1, 2, 1, 5, 0, 0, 0);

    // Vector walk: phase progression and destination register
    prev_ph = 0;
    for (int i = 0; i < 12; i++) begin
      wr_byte(VEC[i][9:2]);
      chk($sformatf("R2/R3/R4/R5 vec%0d phase", i), phase, VEC[i][1:0]);
      chk($sformatf("R12 vec%0d dest reg", i), reg_at(prev_ph), VEC[i][9:2]);
      prev_ph = VEC[i][1:0];
    end
    // 0xFF: async x64, 8 bits, even parity, 2 stop bits
    chk_cfg("R7/R8/R9/R10 0xFF", 0, 0, 64, 8, 1, 1, 4);
    chk("R12 sync1 kept", sync1_byte, 8'hAA);
    chk("R12 sync2 kept", sync2_byte, 8'h16);

    // R11: idle cycles change nothing
    snap_cmd = cmd_byte;
    repeat (5) @(negedge clk);
    chk("R11 phase", phase, 3);
    chk("R11 cmd_byte", cmd_byte, snap_cmd);
    chk("R11 mode_byte", mode_byte, 8'hFF);
    chk("R11 baud_div", baud_div, 64);

    // Async x1, 8 bits, no parity, 1 stop
    do_reset();
    wr_byte(8'h4D);
    chk("R2 phase", phase, 3);
    chk_cfg("R7 0x4D", 0, 0, 1, 8, 0, 0, 2);

    // Sync, single character, 7 bits, even parity
    wr_byte(8'h40);
    chk("R5 cmd kept", cmd_byte, 8'h40);
    wr_byte(8'hB8);
    chk("R3 phase", phase, 1);
    chk_cfg("R3/R8/R9 0xB8", 1, 1, 1, 7, 1, 1, 0);
    wr_byte(8'h7E);
    chk("R3 one sync -> cmd", phase, 3);
    chk("R3 sync1", sync1_byte, 8'h7E);
    chk("R12 cmd untouched", cmd_byte, 8'h40);

    // Async x16, 6 bits, odd parity, 1.5 stop
    wr_byte(8'h40);
    wr_byte(8'h96);
    chk_cfg("R7/R9/R10 0x96", 0, 0, 16, 6, 1, 0, 3);

    // Async with stop field 00 and parity-even bit without enable
    wr_byte(8'h40);
    wr_byte(8'h22);
    chk_cfg("R9/R10 0x22", 0, 0, 16, 5, 0, 0, 0);

    // R6: reset and write in the same cycle, mid-configuration
    wr_byte(8'h40);
    wr_byte(8'h00);
    chk("R6 pre phase", phase, 1);
    @(negedge clk);
    rst = 1'b1;
    ctl_wr = 1'b1;
    ctl_data = 8'h55;
    @(negedge clk);
    rst = 1'b0;
    ctl_wr = 1'b0;
    chk("R6 phase", phase, 0);
    chk("R6 mode_byte", mode_byte, 0);
    chk("R6 sync1_byte", sync1_byte, 0);
    snap_mode = mode_byte;
    wr_byte(8'h4E);
    chk("R6 next write is mode", mode_byte, 8'h4E);
    chk("R6 phase after mode", phase, 3);
    chk("R12 mode changed", int'(mode_byte != snap_mode), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule